// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block reaches indirectly addressed PHY registers over a two-wire management bus. It generates the management clock (MDC) from the system clock through a programmable divider. It drives the data line (MDIO) with an output and an output enable, so the pad can be tri-stated, and it reads the line back through an input pin. A requester presents an operation (read or write), a 5-bit port address, a 5-bit device address, a 16-bit register address and 16 bits of write data, and pulses a start strobe for one cycle.

Each request becomes two management frames sent back to back. The first is a set-address frame that carries the register address. The second is either a write frame that carries the write data, or a read frame in which the PHY returns 16 bits. When the second frame ends, the block pulses `done` for one cycle and, for a read, presents the returned word on `rd_data`. The divider parameter `HALF_DIV` sets the number of system clocks in each MDC half period. With a 100 MHz system clock and the default of 40, MDC runs at 1.25 MHz, which is below the 2.5 MHz ceiling.

Top module: `mdio_c45_master`

## Requirements
- R1: Out of reset and whenever no access is in progress, `busy`, `done`, `mdc`, `mdc_oe` and `mdio_oe` are all 0.
- R2: Every frame is 64 MDC cycles long. It opens with 32 bit times of MDIO = 1, followed by two bit times of 0.
- R3: The 2-bit opcode follows, most significant bit first. Its codes are set-address = 00, write = 01 and read = 11. The code 10 (read with increment) is never issued.
- R4: After the opcode come the 5-bit port address and then the 5-bit device address, each sent most significant bit first.
- R5: Bit times 46 and 47 of every frame, read frames included, are driven by the master as 1 and then 0.
- R6: A write request sends a set-address frame whose last 16 bits are the register address, most significant bit first. A write frame carrying the write data follows with no idle MDC cycle between the two frames, so the access totals 128 MDC rising edges.
- R7: In a read frame, `mdio_oe` is 0 for the last 16 bit times. The master samples `mdio_i` once in each of those bit times, with the first sample becoming bit 15. `rd_data` takes the assembled word when `done` pulses. A write access leaves `rd_data` unchanged.
- R8: MDC starts each bit time low and rises after `HALF_DIV` system clocks. Its period is 2*`HALF_DIV` system clocks throughout an access. `mdio_o` changes only while `mdc` is low, and `mdio_i` is sampled in the last system cycle of the low half.
- R9: `busy` rises in the cycle after an accepted start strobe and stays high until the cycle in which `done` pulses for exactly one cycle. A start strobe that arrives while `busy` is high has no effect on the frames in progress.
- R10: `mdc_oe` is 1 for the whole of every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | One-cycle strobe that requests an access |
| req_read | input | 1 | 1 = read access, 0 = write access |
| req_port | input | 5 | Port address |
| req_dev | input | 5 | Device address |
| req_reg | input | 16 | Register address sent in the set-address frame |
| req_wdata | input | 16 | Data sent in the write frame |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse when an access completes |
| rd_data | output | 16 | Word returned by the last read access |
| mdc | output | 1 | Management clock |
| mdc_oe | output | 1 | Output enable for the MDC pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value read back from the pad |

## Verification
The tests issue write accesses with mixed address patterns and with all-ones and all-zeros fields. Comparing every captured bit time against a frame built independently separates errors in the preamble, opcode, port, device, turnaround and payload fields. Read accesses return the PHY words 8001, 3C96, 0000 and FFFF. These show whether the first sample becomes bit 15, whether the samples are taken at the right edge, and whether the output is released for the correct 16 bit times. One read also receives a second start strobe, with different fields, in the middle of the access; any corruption of the captured frames then shows that the strobe was not ignored.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam int RD_FIRST   = FRAME_BITS - DATA_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {
    OP_SET_ADDR = 2'b00,
    OP_WRITE    = 2'b01,
    OP_READ_INC = 2'b10,
    OP_READ     = 2'b11
  } mdio_op_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ADDR,
    SEQ_DATA
  } seq_state_e;

  // Whole frame, first bit on the wire in the top position.
  function automatic logic [FRAME_BITS-1:0] pack_frame(
    mdio_op_e             op,
    logic [4:0]           prt,
    logic [4:0]           dev,
    logic [DATA_BITS-1:0] payload
  );
    return {{32{1'b1}}, 2'b00, op, prt, dev, 2'b10, payload};
  endfunction

endpackage

// File: rtl/mdio_mdc_divider.sv
module mdio_mdc_divider #(
  parameter int HALF_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = (cnt == CW'(HALF_DIV - 1));
  // Last system cycle of the low half: mdc rises at the next edge.
  assign rise_evt = run && wrap && !mdc;
  // Last system cycle of the high half: mdc falls at the next edge.
  assign fall_evt = run && wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_c45_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_word,
  input  logic                  rd_frame,
  input  logic                  rise_evt,
  input  logic                  fall_evt,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  last_bit,
  output logic [DATA_BITS-1:0]  rd_word
);
  logic [FRAME_BITS-1:0] sh;
  logic [IDX_W-1:0]      idx;
  logic                  active;
  logic                  rd_window;

  assign rd_window = rd_frame && (idx >= IDX_W'(RD_FIRST));
  assign mdio_o    = sh[FRAME_BITS-1];
  assign mdio_oe   = active && !rd_window;
  assign last_bit  = active && fall_evt && (idx == IDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      idx    <= '0;
      active <= 1'b0;
    end else if (load) begin
      sh     <= load_word;
      idx    <= '0;
      active <= 1'b1;
    end else if (last_bit) begin
      active <= 1'b0;
    end else if (active && fall_evt) begin
      sh  <= sh << 1;
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_word <= '0;
    end else if (active && rise_evt && rd_window) begin
      rd_word <= {rd_word[DATA_BITS-2:0], mdio_i};
    end
  end

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int HALF_DIV = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic        req_read,
  input  logic [4:0]  req_port,
  input  logic [4:0]  req_dev,
  input  logic [15:0] req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdc_oe,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  seq_state_e state;
  logic       rd_q;
  logic [4:0] port_q, dev_q;
  logic [15:0] wdata_q;

  logic accept, frame_end, load, run, rd_frame;
  logic rise_evt, fall_evt;
  logic [FRAME_BITS-1:0] load_word;
  logic [DATA_BITS-1:0]  rd_word;
  mdio_op_e data_op;

  assign accept   = req_start && (state == SEQ_IDLE);
  assign load     = accept || (frame_end && (state == SEQ_ADDR));
  assign run      = (state != SEQ_IDLE);
  assign rd_frame = (state == SEQ_DATA) && rd_q;
  assign data_op  = rd_q ? OP_READ : OP_WRITE;
  assign load_word = accept
    ? pack_frame(OP_SET_ADDR, req_port, req_dev, req_reg)
    : pack_frame(data_op, port_q, dev_q, rd_q ? 16'h0000 : wdata_q);

  assign busy   = run;
  assign mdc_oe = run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      rd_q    <= 1'b0;
      port_q  <= '0;
      dev_q   <= '0;
      wdata_q <= '0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        SEQ_IDLE: if (accept) begin
          rd_q    <= req_read;
          port_q  <= req_port;
          dev_q   <= req_dev;
          wdata_q <= req_wdata;
          state   <= SEQ_ADDR;
        end
        SEQ_ADDR: if (frame_end) state <= SEQ_DATA;
        SEQ_DATA: if (frame_end) begin
          state <= SEQ_IDLE;
          done  <= 1'b1;
          if (rd_q) rd_data <= rd_word;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  mdio_mdc_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (load_word),
    .rd_frame  (rd_frame),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .last_bit  (frame_end),
    .rd_word   (rd_word)
  );

endmodule

// File: rtl/mdio_c45_checks.sv
module mdio_c45_checks (
  input logic clk,
  input logic rst_n,
  input logic req_start,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdc_oe,
  input logic mdio_o,
  input logic mdio_oe,
  input logic rd_frame
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc_oe && !mdc));  // R1

  AST_MDIO_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc);  // R8

  AST_RELEASE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdio_oe) |-> rd_frame);  // R7

  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && !busy) |=> busy);  // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(busy)));  // R9

  AST_MDC_OE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> mdc_oe);  // R10

endmodule

bind mdio_c45_master mdio_c45_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_start (req_start),
  .busy      (busy),
  .done      (done),
  .mdc       (mdc),
  .mdc_oe    (mdc_oe),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .rd_frame  (rd_frame)
);

// File: tb/test_mdio_c45_master.sv
`timescale 1ns/1ps
module test_mdio_c45_master;
  localparam int HALF_DIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_start = 1'b0, req_read = 1'b0;
  logic [4:0] req_port = '0, req_dev = '0;
  logic [15:0] req_reg = '0, req_wdata = '0;
  logic busy, done, mdc, mdc_oe, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i = 1'b1;

  always #2.5 clk = ~clk;

  mdio_c45_master #(.HALF_DIV(HALF_DIV)) i_mdio_c45_master (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_read(req_read),
    .req_port(req_port), .req_dev(req_dev), .req_reg(req_reg),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdc_oe(mdc_oe), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int nvec = 0, nfail = 0;
  int cyc = 0, last_rise = 0, nrise = 0, period_bad = 0, dcnt = 0;
  logic [127:0] cap_d, cap_oe;
  logic [15:0] phy_rd = '0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (done) dcnt++;

  always @(posedge mdc) begin
    if (nrise < 128) begin
      cap_d[127-nrise]  = mdio_o;
      cap_oe[127-nrise] = mdio_oe;
    end
    if (nrise > 0 && (cyc - last_rise) != 2*HALF_DIV) period_bad++;
    last_rise = cyc;
    nrise++;
  end

  // PHY model: places a read bit on the line while mdc is low.
  always @(negedge mdc) begin
    if (nrise >= 112 && nrise < 128) mdio_i = phy_rd[127-nrise];
    else mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(int j, logic [1:0] op, logic [4:0] p,
                                   logic [4:0] d, logic [15:0] v);
    if (j < 32) return 1'b1;
    if (j < 34) return 1'b0;
    if (j < 36) return op[35-j];
    if (j < 41) return p[40-j];
    if (j < 46) return d[45-j];
    if (j == 46) return 1'b1;
    if (j == 47) return 1'b0;
    return v[63-j];
  endfunction

  task automatic run_access(input bit rd, input logic [4:0] prt,
                            input logic [4:0] dev, input logic [15:0] rg,
                            input logic [15:0] wd, input logic [15:0] rdv,
                            input bit poke, input string name);
    int t;
    int e_pre, e_op, e_pd, e_ta, e_dat, e_oe, mdcoe_bad;
    logic [15:0] prev_rd;
    logic [127:0] exp_d, exp_oe;
    prev_rd = rd_data;
    nrise = 0; period_bad = 0; dcnt = 0; phy_rd = rdv;
    cap_d = '0; cap_oe = '0; mdcoe_bad = 0;
    @(negedge clk);
    req_read = rd; req_port = prt; req_dev = dev; req_reg = rg; req_wdata = wd;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    check(busy === 1'b1, {"R9 busy after start ", name}, 64'(busy), 64'd1);
    t = 0;
    while (done !== 1'b1 && t < 5000) begin
      @(negedge clk);
      t++;
      if (busy && !mdc_oe) mdcoe_bad++;
      if (poke && t == 100) begin
        req_start = 1'b1; req_read = ~rd; req_port = ~prt; req_dev = ~dev;
        req_reg = ~rg; req_wdata = ~wd;
      end else req_start = 1'b0;
    end
    check(t < 5000, {"R9 done arrives ", name}, 64'(t), 64'd0);
    check(busy === 1'b0, {"R9 busy low at done ", name}, 64'(busy), 64'd0);
    if (rd) check(rd_data === rdv, {"R7 read word ", name}, 64'(rd_data), 64'(rdv));
    else check(rd_data === prev_rd, {"R7 write keeps rd_data ", name},
               64'(rd_data), 64'(prev_rd));
    repeat (3*HALF_DIV) @(negedge clk);
    check(dcnt == 1, {"R9 single done ", name}, 64'(dcnt), 64'd1);
    check(nrise == 128, {"R6 rising edges ", name}, 64'(nrise), 64'd128);
    check(period_bad == 0, {"R8 mdc period ", name}, 64'(period_bad), 64'd0);
    check(mdcoe_bad == 0, {"R10 mdc_oe held ", name}, 64'(mdcoe_bad), 64'd0);
    check(!mdc && !mdc_oe && !mdio_oe && !busy, {"R1 idle after ", name},
          64'({mdc, mdc_oe, mdio_oe, busy}), 64'd0);
    e_pre = 0; e_op = 0; e_pd = 0; e_ta = 0; e_dat = 0; e_oe = 0;
    for (int i = 0; i < 128; i++) begin
      int j;
      logic [1:0] op;
      logic [15:0] v;
      j  = i % 64;
      op = (i < 64) ? 2'b00 : (rd ? 2'b11 : 2'b01);
      v  = (i < 64) ? rg : wd;
      exp_d[127-i]  = exp_bit(j, op, prt, dev, v);
      exp_oe[127-i] = !(rd && i >= 112);
      if (cap_oe[127-i] !== exp_oe[127-i]) e_oe++;
      if (exp_oe[127-i] && cap_d[127-i] !== exp_d[127-i]) begin
        if (j < 34) e_pre++;
        else if (j < 36) e_op++;
        else if (j < 46) e_pd++;
        else if (j < 48) e_ta++;
        else e_dat++;
      end
    end
    check(e_pre == 0, {"R2 preamble/start ", name}, cap_d[127:64], exp_d[127:64]);
    check(e_op == 0, {"R3 opcode ", name}, cap_d[63:0], exp_d[63:0]);
    check(e_pd == 0, {"R4 port/device ", name}, cap_d[63:0], exp_d[63:0]);
    check(e_ta == 0, {"R5 turnaround ", name}, cap_d[63:0], exp_d[63:0]);
    check(e_dat == 0, {"R6 payload ", name}, cap_d[63:0], exp_d[63:0]);
    check(e_oe == 0, {"R7 mdio_oe pattern ", name}, cap_oe[63:0], exp_oe[63:0]);
  endtask

  task automatic test_reset;
    check({busy, done, mdc, mdc_oe, mdio_oe} === 5'b0, "R1 reset state",
          64'({busy, done, mdc, mdc_oe, mdio_oe}), 64'd0);
  endtask

  task automatic test_writes;
    run_access(1'b0, 5'h01, 5'h1E, 16'hC011, 16'hA55A, 16'h0, 1'b0, "write mixed");
    run_access(1'b0, 5'h1F, 5'h00, 16'h0000, 16'hFFFF, 16'h0, 1'b0, "write extremes");
  endtask

  task automatic test_reads;
    run_access(1'b1, 5'h0A, 5'h04, 16'hC000, 16'h0, 16'h8001, 1'b0, "read ends");
    run_access(1'b1, 5'h00, 5'h1F, 16'hFFFF, 16'h0, 16'h0000, 1'b0, "read zeros");
    run_access(1'b1, 5'h15, 5'h0B, 16'h1234, 16'h0, 16'hFFFF, 1'b0, "read ones");
  endtask

  task automatic test_start_while_busy;
    run_access(1'b1, 5'h03, 5'h01, 16'h5AA5, 16'h0, 16'h3C96, 1'b1, "start while busy");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_writes();
    test_reads();
    test_start_while_busy();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #1000000;
    nvec++; nfail++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule